// File: doc/BRIEF.md
# Parseval Energy Checker

This block watches a transform engine from the outside and flags a fault when energy is not conserved across the transform. During one frame it receives two streams of complex samples. The first stream is the samples fed into an N-point transform, and the second is the samples the transform produced. Each valid sample is squared in magnitude (real squared plus imaginary squared) and added into a per-stream energy total.

When the last output sample of the frame arrives, the block compares the two totals. The output total is compared with N times the input total, which is the scaling an unnormalised transform applies. If the absolute difference exceeds a programmable tolerance, the block raises an error flag together with a one-cycle result strobe. The check only detects a fault. It does not identify which output sample is wrong and does not repair anything.

In a typical system, one checker sits beside each transform instance. The control path uses the error flag to trigger recovery.

Top module: `parseval_checker`

## Requirements
- R1: After reset, `checkValid` and `checkError` are 0 and the tolerance holds the value 1.
- R2: Each input sample with `inValid` high adds `inRe*inRe + inIm*inIm` to the input energy total. Each output sample with `outValid` high adds `outRe*outRe + outIm*outIm` to the output energy total. Sample data presented with its valid low has no effect on either total.
- R3: `frameStart` high clears both totals. A sample that is valid in the same cycle becomes the first term of the new total. A `frameStart` in the middle of a frame discards everything accumulated before it.
- R4: `checkValid` is high for exactly the one cycle that follows a cycle in which `outValid` and `frameEnd` are both high. A `frameEnd` with `outValid` low produces no result.
- R5: The result compares the output total with the input total shifted left by LOG2_N (N times the input total). The error is raised when the absolute difference exceeds the tolerance, whichever of the two totals is larger.
- R6: A difference equal to the tolerance passes. A difference of tolerance+1 fails. A tolerance of 0 demands exact equality.
- R7: A cycle with `tolLoad` high stores `tolValue` as the tolerance. The stored value applies to every result reported after that cycle.
- R8: `checkError` is 0 in every cycle in which `checkValid` is 0.
- R9: The totals do not wrap for a frame of N samples that all have both parts at the most negative value, on either stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| frameStart | input | 1 | Clears both energy totals |
| inValid | input | 1 | Input-side sample strobe |
| inRe | input | IN_W | Input-side sample, real part, signed |
| inIm | input | IN_W | Input-side sample, imaginary part, signed |
| outValid | input | 1 | Output-side sample strobe |
| outRe | input | OUT_W | Output-side sample, real part, signed |
| outIm | input | OUT_W | Output-side sample, imaginary part, signed |
| frameEnd | input | 1 | Marks the last output sample; qualified by outValid |
| tolLoad | input | 1 | Writes tolValue into the tolerance register |
| tolValue | input | TOL_W | New tolerance |
| checkValid | output | 1 | One-cycle result strobe |
| checkError | output | 1 | Energy mismatch beyond tolerance; valid with checkValid |

## Verification
The main sweep builds frames whose energy mismatch is a chosen small integer. The mismatch is positive when extra output energy is added and negative when an extra input sample is added. Each mismatch is tried against tolerances on both sides of it, including zero, so the pass/fail boundary and the sign independence are both separated from a plain equality test. Inside each frame, the sweep also presents garbage data with the strobes low, and it starts the frame with a sample already valid on `frameStart`. Full-scale frames on each stream, compared with an empty or matching opposite stream, reveal any accumulator too narrow to hold the worst case. A restarted frame shows that stale energy is discarded, and a stray `frameEnd` shows that no result appears without the last output sample.

// File: rtl/psc_pkg.sv
package psc_pkg;

  // Strobes from the control module to the datapath.
  typedef struct packed {
    logic clearAcc;   // restart both energy totals
    logic loadTol;    // capture a new tolerance
    logic evalNow;    // the totals are final; report the comparison
  } pscStrobes_t;

  function automatic int maxInt(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/psc_energy_acc.sv
module psc_energy_acc #(
  parameter int SAMPLE_W = 8,
  parameter int ACC_W    = 19
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       clear,
  input  logic                       sampleValid,
  input  logic signed [SAMPLE_W-1:0] sampleRe,
  input  logic signed [SAMPLE_W-1:0] sampleIm,
  output logic        [ACC_W-1:0]    total
);

  localparam int SQ_W = 2 * SAMPLE_W;

  logic signed [SQ_W-1:0] reSq;
  logic signed [SQ_W-1:0] imSq;
  logic        [SQ_W-1:0] energy;
  logic        [ACC_W-1:0] energyExt;

  // Two squarings and one add per sample; the magnitude squared is
  // at most 2^(SQ_W-1), so it fits in SQ_W unsigned bits.
  always_comb begin
    reSq      = SQ_W'(sampleRe) * SQ_W'(sampleRe);
    imSq      = SQ_W'(sampleIm) * SQ_W'(sampleIm);
    energy    = $unsigned(reSq) + $unsigned(imSq);
    energyExt = ACC_W'(energy);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      total <= '0;
    end else if (clear) begin
      total <= sampleValid ? energyExt : '0;
    end else if (sampleValid) begin
      total <= total + energyExt;
    end
  end

  // R3
  clear_empty_chk: assert property (@(posedge clk) disable iff (!rstN)
    (clear && !sampleValid) |=> (total == '0));

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!clear && !sampleValid) |=> $stable(total));

  // R9
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!clear && sampleValid) |=> (total >= $past(total)));

endmodule

// File: rtl/psc_datapath.sv
module psc_datapath
  import psc_pkg::*;
#(
  parameter int IN_W      = 8,
  parameter int OUT_W     = 11,
  parameter int LOG2_N    = 3,
  parameter int TOL_W     = 16,
  parameter int TOL_RESET = 1
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  pscStrobes_t             strobes,
  input  logic                    inValid,
  input  logic signed [IN_W-1:0]  inRe,
  input  logic signed [IN_W-1:0]  inIm,
  input  logic                    outValid,
  input  logic signed [OUT_W-1:0] outRe,
  input  logic signed [OUT_W-1:0] outIm,
  input  logic [TOL_W-1:0]        tolValue,
  output logic                    checkError
);

  // Each total holds N worst-case squared magnitudes.
  localparam int IN_ACC_W  = 2 * IN_W + LOG2_N;
  localparam int OUT_ACC_W = 2 * OUT_W + LOG2_N;
  localparam int SCALED_W  = IN_ACC_W + LOG2_N;
  // One extra bit so the difference is representable in two's complement.
  localparam int CMP_W     = maxInt(maxInt(SCALED_W, OUT_ACC_W), TOL_W) + 1;

  logic [IN_ACC_W-1:0]  inTotal;
  logic [OUT_ACC_W-1:0] outTotal;
  logic [TOL_W-1:0]     tolReg;
  logic [CMP_W-1:0]     scaledIn;
  logic [CMP_W-1:0]     outExt;
  logic [CMP_W-1:0]     diff;
  logic [CMP_W-1:0]     absDiff;
  logic                 mismatch;

  psc_energy_acc #(
    .SAMPLE_W (IN_W),
    .ACC_W    (IN_ACC_W)
  ) i_inAcc (
    .clk         (clk),
    .rstN        (rstN),
    .clear       (strobes.clearAcc),
    .sampleValid (inValid),
    .sampleRe    (inRe),
    .sampleIm    (inIm),
    .total       (inTotal)
  );

  psc_energy_acc #(
    .SAMPLE_W (OUT_W),
    .ACC_W    (OUT_ACC_W)
  ) i_outAcc (
    .clk         (clk),
    .rstN        (rstN),
    .clear       (strobes.clearAcc),
    .sampleValid (outValid),
    .sampleRe    (outRe),
    .sampleIm    (outIm),
    .total       (outTotal)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tolReg <= TOL_W'(TOL_RESET);
    end else if (strobes.loadTol) begin
      tolReg <= tolValue;
    end
  end

  // Scale by N with a shift, take the magnitude of the difference, compare.
  always_comb begin
    scaledIn = CMP_W'(inTotal) << LOG2_N;
    outExt   = CMP_W'(outTotal);
    diff     = outExt - scaledIn;
    absDiff  = diff[CMP_W-1] ? (CMP_W'(0) - diff) : diff;
    mismatch = absDiff > CMP_W'(tolReg);
  end

  assign checkError = strobes.evalNow & mismatch;

  // R7
  tol_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.loadTol |=> (tolReg == $past(tolValue)));

  // R7
  tol_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.loadTol |=> $stable(tolReg));

endmodule

// File: rtl/psc_control.sv
module psc_control
  import psc_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        frameStart,
  input  logic        outValid,
  input  logic        frameEnd,
  input  logic        tolLoad,
  output pscStrobes_t strobes,
  output logic        checkValid
);

  logic evalPending;

  // The last output sample lands in the total at this same edge, so the
  // comparison is ready in the following cycle.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      evalPending <= 1'b0;
    end else begin
      evalPending <= outValid & frameEnd;
    end
  end

  always_comb begin
    strobes.clearAcc = frameStart;
    strobes.loadTol  = tolLoad;
    strobes.evalNow  = evalPending;
  end

  assign checkValid = evalPending;

  // R4
  result_follows_end_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && frameEnd) |=> checkValid);

  // R4
  stray_end_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(outValid && frameEnd) |=> !checkValid);

endmodule

// File: rtl/parseval_checker.sv
module parseval_checker
  import psc_pkg::*;
#(
  parameter int IN_W      = 8,
  parameter int LOG2_N    = 3,
  parameter int OUT_W     = IN_W + LOG2_N,
  parameter int TOL_W     = 16,
  parameter int TOL_RESET = 1
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    frameStart,
  input  logic                    inValid,
  input  logic signed [IN_W-1:0]  inRe,
  input  logic signed [IN_W-1:0]  inIm,
  input  logic                    outValid,
  input  logic signed [OUT_W-1:0] outRe,
  input  logic signed [OUT_W-1:0] outIm,
  input  logic                    frameEnd,
  input  logic                    tolLoad,
  input  logic [TOL_W-1:0]        tolValue,
  output logic                    checkValid,
  output logic                    checkError
);

  pscStrobes_t strobes;

  psc_control i_control (
    .clk        (clk),
    .rstN       (rstN),
    .frameStart (frameStart),
    .outValid   (outValid),
    .frameEnd   (frameEnd),
    .tolLoad    (tolLoad),
    .strobes    (strobes),
    .checkValid (checkValid)
  );

  psc_datapath #(
    .IN_W      (IN_W),
    .OUT_W     (OUT_W),
    .LOG2_N    (LOG2_N),
    .TOL_W     (TOL_W),
    .TOL_RESET (TOL_RESET)
  ) i_datapath (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .inValid    (inValid),
    .inRe       (inRe),
    .inIm       (inIm),
    .outValid   (outValid),
    .outRe      (outRe),
    .outIm      (outIm),
    .tolValue   (tolValue),
    .checkError (checkError)
  );

  // R8
  error_qualified_chk: assert property (@(posedge clk) disable iff (!rstN)
    !checkValid |-> !checkError);

endmodule

// File: tb/test_parseval_checker.sv
module test_parseval_checker;

  localparam int CLK_PERIOD = 10;
  localparam int IN_W   = 8;
  localparam int LOG2_N = 3;
  localparam int N      = 1 << LOG2_N;
  localparam int OUT_W  = IN_W + LOG2_N;
  localparam int TOL_W  = 16;

  logic                    clk = 1'b0;
  logic                    rstN = 1'b0;
  logic                    frameStart = 1'b0;
  logic                    inValid = 1'b0;
  logic signed [IN_W-1:0]  inRe = '0;
  logic signed [IN_W-1:0]  inIm = '0;
  logic                    outValid = 1'b0;
  logic signed [OUT_W-1:0] outRe = '0;
  logic signed [OUT_W-1:0] outIm = '0;
  logic                    frameEnd = 1'b0;
  logic                    tolLoad = 1'b0;
  logic [TOL_W-1:0]        tolValue = '0;
  logic                    checkValid;
  logic                    checkError;

  int checks = 0;
  int errors = 0;
  int tolList [5] = '{0, 1, 2, 5, 8};

  always #(CLK_PERIOD / 2) clk = ~clk;

  parseval_checker #(
    .IN_W   (IN_W),
    .LOG2_N (LOG2_N),
    .OUT_W  (OUT_W),
    .TOL_W  (TOL_W)
  ) i_parseval_checker (
    .clk        (clk),
    .rstN       (rstN),
    .frameStart (frameStart),
    .inValid    (inValid),
    .inRe       (inRe),
    .inIm       (inIm),
    .outValid   (outValid),
    .outRe      (outRe),
    .outIm      (outIm),
    .frameEnd   (frameEnd),
    .tolLoad    (tolLoad),
    .tolValue   (tolValue),
    .checkValid (checkValid),
    .checkError (checkError)
  );

  task automatic checkEq(input string req, input int actual, input int expected);
    checks++;
    if (actual != expected) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, actual, expected);
    end
  endtask

  task automatic drive(input logic fs, input logic iv, input int ir, input int ii,
                       input logic ov, input int orr, input int oi, input logic fe);
    @(negedge clk);
    frameStart = fs;
    inValid    = iv;
    inRe       = IN_W'(ir);
    inIm       = IN_W'(ii);
    outValid   = ov;
    outRe      = OUT_W'(orr);
    outIm      = OUT_W'(oi);
    frameEnd   = fe;
    tolLoad    = 1'b0;
  endtask

  task automatic setTol(input int v);
    drive(0, 0, 0, 0, 0, 0, 0, 0);
    tolLoad  = 1'b1;
    tolValue = TOL_W'(v);
  endtask

  // The last sample was applied before the previous edge: the result is
  // visible now, and must be gone one cycle later.
  task automatic expectResult(input int expErr, input string req);
    drive(0, 0, 0, 0, 0, 0, 0, 0);
    checkEq({req, " R4 valid"}, int'(checkValid), 1);
    checkEq({req, " error"}, int'(checkError), expErr);
    drive(0, 0, 0, 0, 0, 0, 0, 0);
    checkEq("R4 single pulse", int'(checkValid), 0);
    checkEq("R8 error gated", int'(checkError), 0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog actual %0d expected %0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1: reset state
    drive(0, 0, 0, 0, 0, 0, 0, 0);
    checkEq("R1 valid at reset", int'(checkValid), 0);
    checkEq("R1 error at reset", int'(checkError), 0);

    // R1: reset tolerance is 1 -> mismatch 1 passes, 2 fails
    drive(1, 1, 1, 0, 0, 0, 0, 0);
    drive(0, 0, 0, 0, 1, 2, 2, 0);
    drive(0, 0, 0, 0, 1, 1, 0, 1);
    expectResult(0, "R1 tol1 diff1");
    drive(1, 1, 1, 0, 0, 0, 0, 0);
    drive(0, 0, 0, 0, 1, 2, 2, 0);
    drive(0, 0, 0, 0, 1, 1, 1, 1);
    expectResult(1, "R1 tol1 diff2");

    // R5 R6 R2 R3 R7: sweep of mismatch vs tolerance
    for (int ai = 0; ai < 4; ai++) begin
      for (int t = 0; t < 2; t++) begin
        for (int s = 0; s < 4; s++) begin
          for (int u = 0; u < 4; u++) begin
            for (int ti = 0; ti < 5; ti++) begin
              int a;
              int d;
              int expErr;
              a = (ai == 0) ? 1 : (ai == 1) ? 3 : (ai == 2) ? -5 : 7;
              d = s * s + u * u - N * t * t;
              if (d < 0) d = -d;
              expErr = (d > tolList[ti]) ? 1 : 0;
              setTol(tolList[ti]);                      // R7
              drive(1, 1, a, 0, 0, 0, 0, 0);            // R3 sample with start
              drive(0, 0, 99, -77, 0, 500, -300, 0);    // R2 ignored data
              drive(0, 1, t, 0, 1, 2 * a, 2 * a, 0);
              drive(0, 0, 0, 0, 1, s, u, 1);
              expectResult(expErr, "R5 R6 R2 R3 R7 sweep");
            end
          end
        end
      end
    end

    // R9: full-scale input matched by output, exact tolerance
    setTol(0);
    drive(1, 0, 0, 0, 0, 0, 0, 0);
    for (int k = 0; k < N; k++) drive(0, 1, -128, -128, 0, 0, 0, 0);
    for (int k = 0; k < N / 2; k++) drive(0, 0, 0, 0, 1, -512, -512, 0);
    for (int k = 0; k < N / 2 - 1; k++) drive(0, 0, 0, 0, 1, 0, 0, 0);
    drive(0, 0, 0, 0, 1, 0, 0, 1);
    expectResult(0, "R9 full-scale input matched");

    // R9: full-scale output against empty input
    drive(1, 0, 0, 0, 0, 0, 0, 0);
    for (int k = 0; k < N - 1; k++) drive(0, 0, 0, 0, 1, -1024, -1024, 0);
    drive(0, 0, 0, 0, 1, -1024, -1024, 1);
    expectResult(1, "R9 full-scale output");

    // R9: full-scale input against zero output
    drive(1, 0, 0, 0, 0, 0, 0, 0);
    for (int k = 0; k < N; k++) drive(0, 1, -128, -128, 0, 0, 0, 0);
    drive(0, 0, 0, 0, 1, 0, 0, 1);
    expectResult(1, "R9 full-scale input");

    // R3: restart mid-frame discards the stale mismatch
    drive(1, 1, 5, 5, 0, 0, 0, 0);
    drive(0, 0, 0, 0, 1, 3, 0, 0);
    drive(1, 0, 0, 0, 0, 0, 0, 0);
    drive(0, 1, 2, 1, 0, 0, 0, 0);
    drive(0, 0, 0, 0, 1, 4, 2, 0);
    drive(0, 0, 0, 0, 1, 4, 2, 1);
    expectResult(0, "R3 restart");

    // R4: frameEnd without outValid yields no result
    drive(1, 1, 3, 0, 0, 0, 0, 0);
    drive(0, 0, 0, 0, 0, 0, 0, 1);
    drive(0, 0, 0, 0, 0, 0, 0, 0);
    checkEq("R4 stray end", int'(checkValid), 0);
    checkEq("R8 stray end error", int'(checkError), 0);

    // R7: newly loaded tolerance applies, then a tighter one
    setTol(72);
    drive(1, 1, 3, 0, 0, 0, 0, 0);
    drive(0, 0, 0, 0, 1, 0, 0, 1);
    expectResult(0, "R7 loose tolerance");
    setTol(71);
    drive(1, 1, 3, 0, 0, 0, 0, 0);
    drive(0, 0, 0, 0, 1, 0, 0, 1);
    expectResult(1, "R7 tight tolerance");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule